// File: doc/BRIEF.md
# Reversible Gate-List Duplicate Canceller

This block takes a cascade of reversible multi-control NOT gates, one gate per cycle, and returns the same cascade with redundant gate pairs removed. Each gate is given as the binary index of its target line and a mask of its control lines. A gate applied twice in a row is an identity, so both copies can be dropped. Two gates also exchange places freely when neither gate's target is one of the other's controls. This lets the block cancel a pair that has a small number of such commuting gates between them.

The gate list is loaded into local storage. The block then makes passes over it in place. Each pass rebuilds the surviving list as a stack inside the same storage. Every gate read is compared with the stack top and with entries just below it, as long as the gates it would move past commute with it. Passes repeat until one of them removes nothing. The reduced list is then streamed out in its original relative order. The block reports how many gates were deleted and raises `done`, which stays high until reset.

Top module: `gate_cancel_opt`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `done` is 0 and `del_count` is 0.
- R2: A gate is taken on each rising edge where `in_valid` and `in_ready` are both high. The list ends with the gate that carries `in_last`, or with the DEPTH-th gate if that comes first. From the next cycle on, `in_ready` is 0.
- R3: A gate consists of a target line index (binary, in `in_tgt`) and a control mask (bit i of `in_ctl` set means line i is a control). Two gates are identical when both fields are equal. When two identical gates stand next to each other, both are removed and `del_count` grows by 2.
- R4: Gates a and b commute when bit `tgt(b)` of `ctl(a)` is 0 and bit `tgt(a)` of `ctl(b)` is 0. A gate cancels an identical earlier gate that has up to LOOK-1 gates between them, provided all of those gates commute with it. With LOOK or more gates between them, or with any gate between them that does not commute, both gates are kept.
- R5: After a pair is removed, the gate that was below it becomes the new neighbour of later gates and may cancel with them in the same pass (A B B A reduces to nothing).
- R6: Passes over the list repeat until a pass deletes nothing. A pair that only becomes cancellable after an earlier removal is still removed.
- R7: The surviving gates come out in their original relative order as one unbroken run of `out_valid` cycles, with `out_last` high only on the final one. If no gates survive, `out_valid` never rises.
- R8: `del_count` equals the number of gates taken minus the number emitted. It is always even and does not change while gates are being emitted. `done` rises after the last output and holds until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input gate present |
| in_ready | output | 1 | Block is accepting the gate list |
| in_tgt | input | TW | Target line index of the input gate |
| in_ctl | input | NL | Control-line mask of the input gate |
| in_last | input | 1 | Final gate of the list |
| out_valid | output | 1 | Output gate present |
| out_tgt | output | TW | Target line index of the output gate |
| out_ctl | output | NL | Control-line mask of the output gate |
| out_last | output | 1 | Final surviving gate |
| del_count | output | PW | Number of gates removed |
| done | output | 1 | Reduction and output finished |

## Verification
`in_ready` falls in the cycle after the edge that takes the final gate, so the bench samples it at the falling edge right after driving that gate. Reduction takes a number of cycles that depends on the data: one cycle per gate for each pass, plus one cycle to close each pass. For that reason the bench does not predict the cycle of each output. At every falling edge it records any gate shown with `out_valid`, and it stops when `done` is seen. `del_count` and the gathered list are compared only after `done` has risen, because both are final from then on.

// File: rtl/gate_cancel_opt.sv
module gate_cancel_opt #(
  parameter int NL    = 3,
  parameter int DEPTH = 16,
  parameter int LOOK  = 2,
  localparam int TW = (NL > 1) ? $clog2(NL) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [TW-1:0] in_tgt,
  input  logic [NL-1:0] in_ctl,
  input  logic          in_last,
  output logic          out_valid,
  output logic [TW-1:0] out_tgt,
  output logic [NL-1:0] out_ctl,
  output logic          out_last,
  output logic [PW-1:0] del_count,
  output logic          done
);
  typedef enum logic [1:0] {LOAD, REDUCE, EMIT, FIN} st_t;
  st_t st;

  logic [TW-1:0] mt [DEPTH];
  logic [NL-1:0] mc [DEPTH];
  logic [PW-1:0] len, r, w;
  logic          pass_del;

  logic [TW-1:0] g_t, e_t;
  logic [NL-1:0] g_c, e_c;
  logic          hit, blk;
  int            hj;

  assign g_t = mt[r[AW-1:0]];
  assign g_c = mc[r[AW-1:0]];

  assign in_ready  = (st == LOAD);
  assign out_valid = (st == EMIT) && (r < len);
  assign out_tgt   = g_t;
  assign out_ctl   = g_c;
  assign out_last  = out_valid && (r == len - PW'(1));
  assign done      = (st == FIN);

  always_comb begin
    hit = 1'b0; blk = 1'b0; hj = 0;
    e_t = '0;   e_c = '0;
    for (int j = 1; j <= LOOK; j++) begin
      if (!hit && !blk && int'(w) >= j) begin
        e_t = mt[AW'(int'(w) - j)];
        e_c = mc[AW'(int'(w) - j)];
        if (e_t == g_t && e_c == g_c) begin
          hit = 1'b1; hj = j;
        end else if (g_c[e_t] || e_c[g_t]) begin
          blk = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= LOAD; len <= '0; r <= '0; w <= '0;
      pass_del <= 1'b0; del_count <= '0;
    end else begin
      case (st)
        LOAD: if (in_valid) begin
          mt[len[AW-1:0]] <= in_tgt;
          mc[len[AW-1:0]] <= in_ctl;
          len <= len + PW'(1);
          if (in_last || len == PW'(DEPTH - 1)) st <= REDUCE;
        end
        REDUCE: if (r == len) begin
          r <= '0;
          if (pass_del) begin
            len <= w; w <= '0; pass_del <= 1'b0;
          end else begin
            st <= EMIT;
          end
        end else begin
          if (hit) begin
            for (int i = 0; i < DEPTH - 1; i++)
              if (i >= int'(w) - hj && i < int'(w) - 1) begin
                mt[i] <= mt[i+1];
                mc[i] <= mc[i+1];
              end
            w <= w - PW'(1);
            del_count <= del_count + PW'(2);
            pass_del <= 1'b1;
          end else begin
            mt[w[AW-1:0]] <= g_t;
            mc[w[AW-1:0]] <= g_c;
            w <= w + PW'(1);
          end
          r <= r + PW'(1);
        end
        EMIT: begin
          r <= r + PW'(1);
          if (r + PW'(1) >= len) st <= FIN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gate_cancel_opt_chk.sv
module gate_cancel_opt_chk #(
  parameter int TW = 2,
  parameter int NL = 3,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_last,
  input logic [PW-1:0] del_count,
  input logic          done
);
  p_del_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !del_count[0]);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_del_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(del_count));
  p_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  p_no_load_late_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || done) |-> !in_ready);
endmodule

bind gate_cancel_opt gate_cancel_opt_chk #(.TW(TW), .NL(NL), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_last(out_last), .del_count(del_count), .done(done)
);

// File: tb/gate_cancel_opt_tb.sv
module gate_cancel_opt_tb;
  localparam int CLK_P = 10;
  localparam int NL = 3, DEPTH = 8, LOOK = 2, TW = 2, PW = 4;
  localparam int LIMIT = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [TW-1:0] in_tgt = '0;
  logic [NL-1:0] in_ctl = '0;
  logic in_ready, out_valid, out_last, done;
  logic [TW-1:0] out_tgt;
  logic [NL-1:0] out_ctl;
  logic [PW-1:0] del_count;

  always #(CLK_P/2) clk = ~clk;

  gate_cancel_opt #(.NL(NL), .DEPTH(DEPTH), .LOOK(LOOK)) u_dut (.*);

  int n_tests = 0, n_fail = 0;
  int in_t[DEPTH], in_c[DEPTH], n_in;
  int ex_t[DEPTH], ex_c[DEPTH], n_ex, ex_del;
  int go_t[DEPTH+1], go_c[DEPTH+1], n_go;

  function automatic int gtg(int k); return k / 4; endfunction
  function automatic int gcl(int k);
    int t = k / 4, m = k % 4;
    int o0 = (t == 0) ? 1 : 0;
    int o1 = (t == 2) ? 1 : 2;
    return ((m & 1) << o0) | (((m >> 1) & 1) << o1);
  endfunction
  function automatic bit comm(int a, int b);
    return !((gcl(a) >> gtg(b)) & 1) && !((gcl(b) >> gtg(a)) & 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic add_in(int t, int c); in_t[n_in] = t; in_c[n_in] = c; n_in++; endtask
  task automatic add_ex(int t, int c); ex_t[n_ex] = t; ex_c[n_ex] = c; n_ex++; endtask
  task automatic clr(); n_in = 0; n_ex = 0; ex_del = 0; endtask

  task automatic run(string req, bit use_last);
    int cyc;
    bit lastok, same;
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < n_in; i++) begin
      in_valid = 1'b1; in_tgt = TW'(in_t[i]); in_ctl = NL'(in_c[i]);
      in_last = use_last && (i == n_in - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk(in_ready == 1'b0, "R2 in_ready after list end", int'(in_ready), 0);
    n_go = 0; cyc = 0; lastok = 1'b1;
    while (!done && cyc < LIMIT) begin
      if (out_valid && n_go <= DEPTH) begin
        go_t[n_go] = int'(out_tgt); go_c[n_go] = int'(out_ctl);
        if (out_last != (n_go == n_ex - 1)) lastok = 1'b0;
        n_go++;
      end
      @(negedge clk); cyc++;
    end
    chk(done == 1'b1, "watchdog done", int'(done), 1);
    chk(n_go == n_ex, {req, " R7 output count"}, n_go, n_ex);
    chk(int'(del_count) == ex_del, {req, " R8 del_count"}, int'(del_count), ex_del);
    same = (n_go == n_ex) && lastok;
    for (int i = 0; i < n_ex && i < n_go; i++)
      if (go_t[i] != ex_t[i] || go_c[i] != ex_c[i]) same = 1'b0;
    chk(same, {req, " R7 list content/order"}, n_go, n_ex);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(del_count == '0, "R1 del_count", int'(del_count), 0);

    // R3: every ordered pair of gates
    for (int a = 0; a < 12; a++)
      for (int b = 0; b < 12; b++) begin
        clr(); add_in(gtg(a), gcl(a)); add_in(gtg(b), gcl(b));
        if (a == b) ex_del = 2;
        else begin add_ex(gtg(a), gcl(a)); add_ex(gtg(b), gcl(b)); end
        run("R3 pair", 1'b1);
      end

    // R4: a b a over all gate choices
    for (int a = 0; a < 12; a++)
      for (int b = 0; b < 12; b++) begin
        clr(); add_in(gtg(a), gcl(a)); add_in(gtg(b), gcl(b)); add_in(gtg(a), gcl(a));
        if (a == b) begin ex_del = 2; add_ex(gtg(a), gcl(a)); end
        else if (comm(a, b)) begin ex_del = 2; add_ex(gtg(b), gcl(b)); end
        else begin
          add_ex(gtg(a), gcl(a)); add_ex(gtg(b), gcl(b)); add_ex(gtg(a), gcl(a));
        end
        run("R4 sandwich", 1'b1);
      end

    // R4 window boundary: two commuting gates between copies of the same gate
    clr(); add_in(0,0); add_in(1,0); add_in(2,0); add_in(0,0);
    add_ex(0,0); add_ex(1,0); add_ex(2,0); add_ex(0,0);
    run("R4 beyond window", 1'b1);

    // R5: A B B A collapses completely
    clr(); add_in(0,0); add_in(1,1); add_in(1,1); add_in(0,0); ex_del = 4;
    run("R5 nested", 1'b1);

    // R6: U Q Y U Y needs a second pass, leaves Q
    clr(); add_in(0,0); add_in(1,0); add_in(2,0); add_in(0,0); add_in(2,0);
    add_ex(1,0); ex_del = 4;
    run("R6 repeat pass", 1'b1);

    // R2: DEPTH gates with no in_last, none cancel
    clr();
    for (int i = 0; i < DEPTH; i++)
      if (i % 2 == 0) begin add_in(0,0); add_ex(0,0); end
      else begin add_in(1,1); add_ex(1,1); end
    run("R2 full depth", 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule